// File: doc/BRIEF.md
# Wide-Key Search Command Deserializer

This block sits on the device side of a search-engine command port. It watches the command-valid strobe, the 9-bit command bus and the 68-bit data bus, and rebuilds a 272-bit search that the host sends as four consecutive cycles, named A, B, C and D here. One cycle is a search cycle when command-valid is high and the opcode field `cmd_i[1:0]` equals `2'b10`. The width flag `cmd_i[2]` marks where the sequence starts. It is 1 in cycle A and must be 0 in cycle C. The block follows the phase from these two signals.

Each phase adds different fields. Cycle A gives the top data slice and the upper mask-pair index. Cycle B gives the second slice. Cycle C gives the third slice, the lower mask-pair index and the result-address tag. Cycle D gives the last slice and the result-register index. The clock edge after cycle D loads the whole key and all indexes into output registers and raises a one-cycle ready pulse. If the sequence breaks, the block raises a one-cycle error pulse instead, and it goes back to waiting for a cycle A. The downstream compare array, masking and cascade logic read the registered outputs.

Top module: `wks_deser`

## Requirements
- R1: While reset is asserted and after it is released, `srch_rdy_o` and `proto_err_o` are 0 and every captured output field is 0.
- R2: Only cycles with `cmd_vld_i`=1 and `cmd_i[1:0]`=2'b10 count as search cycles. While the block waits for cycle A, any other cycle produces no ready, no error and no change of any output.
- R3: In the key, the cycle-A data appears at bits 271:204, cycle B at 203:136, cycle C at 135:68 and cycle D at 67:0.
- R4: `hi_mask_idx_o` takes `cmd_i[5:3]` of cycle A. `lo_mask_idx_o` takes `cmd_i[5:3]` of cycle C.
- R5: `addr_tag_o` takes `cmd_i[8:7]` of cycle C. `rslt_sel_o` takes `cmd_i[8:6]` of cycle D.
- R6: `srch_rdy_o` is high for exactly the one cycle after cycle D. All output fields take their new values in that same cycle.
- R7: Output fields keep their values until the next ready pulse, including across errors and unfinished sequences.
- R8: These command bits have no effect on any output: `cmd_i[8:6]` in A, `cmd_i[8:2]` in B, `cmd_i[6]` in C and `cmd_i[5:2]` in D.
- R9: In phase B, C or D, a cycle that is not a search cycle makes `proto_err_o` pulse for one cycle after it. The block then waits for cycle A, and the breaking cycle is not taken as a new cycle A.
- R10: A search cycle with `cmd_i[2]`=0 while the block waits for A, or with `cmd_i[2]`=1 in phase C, gives the same error pulse and return to waiting.
- R11: A cycle A that directly follows cycle D is accepted with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld_i | input | 1 | Command valid strobe |
| cmd_i | input | 9 | Command bus: opcode [1:0], width flag [2], fields [8:3] |
| dq_i | input | DATA_W (68) | Data slice for the current cycle |
| key_o | output | 4*DATA_W (272) | Assembled search key |
| hi_mask_idx_o | output | 3 | Mask-pair index for the upper half of the key |
| lo_mask_idx_o | output | 3 | Mask-pair index for the lower half of the key |
| addr_tag_o | output | 2 | Tag placed on the top result-address bits |
| rslt_sel_o | output | 3 | Result register index |
| srch_rdy_o | output | 1 | One-cycle pulse when a new key is on the outputs |
| proto_err_o | output | 1 | One-cycle pulse when the sequence is broken |

## Verification
The assertions assume that all inputs carry known values from the first edge after reset. They also assume that any cycle D sends the key tail on `dq_i` in the same cycle, so the registered key can be compared with the sampled data one cycle later. The bench changes inputs only on falling edges and drives only 0 or 1. Each sequence is either a complete search or one that is broken on purpose, with a single fault per run and arbitrary values on the don't-care command bits.

// File: rtl/wks_pkg.sv
package wks_pkg;
  localparam int unsigned PHASES  = 4;
  localparam int unsigned CMD_W   = 9;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned TAG_W   = 2;
  localparam int unsigned SEL_W   = 3;
  localparam logic [1:0]  OP_SRCH = 2'b10;

  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_C = 2'd2,
    PH_D = 2'd3
  } phase_e;
endpackage

// File: rtl/wks_phase_fsm.sv
module wks_phase_fsm
  import wks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  output logic [PHASES-1:0] cap_o,
  output logic              err_o
);

  phase_e ph_q, ph_nxt;
  logic   err_nxt;
  logic   is_srch;

  always_comb begin
    is_srch = vld_i && (op_i == OP_SRCH);
    ph_nxt  = ph_q;
    cap_o   = '0;
    err_nxt = 1'b0;
    unique case (ph_q)
      PH_A: begin
        if (is_srch) begin
          if (wide_i) begin
            cap_o[0] = 1'b1;
            ph_nxt   = PH_B;
          end else begin
            err_nxt  = 1'b1;
          end
        end
      end
      PH_B: begin
        if (is_srch) begin
          cap_o[1] = 1'b1;
          ph_nxt   = PH_C;
        end else begin
          err_nxt  = 1'b1;
          ph_nxt   = PH_A;
        end
      end
      PH_C: begin
        if (is_srch && !wide_i) begin
          cap_o[2] = 1'b1;
          ph_nxt   = PH_D;
        end else begin
          err_nxt  = 1'b1;
          ph_nxt   = PH_A;
        end
      end
      PH_D: begin
        ph_nxt = PH_A;
        if (is_srch) cap_o[3] = 1'b1;
        else         err_nxt  = 1'b1;
      end
      default: ph_nxt = PH_A;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_A;
      err_o <= 1'b0;
    end else begin
      ph_q  <= ph_nxt;
      err_o <= err_nxt;
    end
  end

  AST_ERR_ON_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_A && !is_srch) |=> (err_o && ph_q == PH_A)); // R9

  AST_ERR_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_C && is_srch && wide_i) |=> (err_o && ph_q == PH_A)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_A && !is_srch) |=> (!err_o && ph_q == PH_A)); // R2

endmodule

// File: rtl/wks_field_capture.sv
module wks_field_capture
  import wks_pkg::*;
#(
  parameter int unsigned DATA_W = 68,
  localparam int unsigned KEY_W = DATA_W * PHASES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] cap_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [KEY_W-1:0]  key_o,
  output logic [IDX_W-1:0]  hi_o,
  output logic [IDX_W-1:0]  lo_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              rdy_o
);

  localparam int unsigned LAST = PHASES - 1;

  logic [DATA_W-1:0] stg_q [LAST];
  logic [KEY_W-1:0]  key_cat;
  logic [IDX_W-1:0]  hi_stg_q, lo_stg_q;
  logic [TAG_W-1:0]  tag_stg_q;

  for (genvar g = 0; g < LAST; g++) begin : g_slice
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stg_q[g] <= '0;
      else if (cap_i[g]) stg_q[g] <= dq_i;
    end
    assign key_cat[KEY_W-1-g*DATA_W -: DATA_W] = stg_q[g];
  end
  assign key_cat[DATA_W-1:0] = dq_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_stg_q  <= '0;
      lo_stg_q  <= '0;
      tag_stg_q <= '0;
    end else begin
      if (cap_i[0]) hi_stg_q <= idx_i;
      if (cap_i[2]) begin
        lo_stg_q  <= idx_i;
        tag_stg_q <= tag_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_o <= '0;
      hi_o  <= '0;
      lo_o  <= '0;
      tag_o <= '0;
      sel_o <= '0;
      rdy_o <= 1'b0;
    end else begin
      rdy_o <= cap_i[LAST];
      if (cap_i[LAST]) begin
        key_o <= key_cat;
        hi_o  <= hi_stg_q;
        lo_o  <= lo_stg_q;
        tag_o <= tag_stg_q;
        sel_o <= sel_i;
      end
    end
  end

  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o); // R6

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_o |-> ($stable(key_o) && $stable(hi_o) && $stable(lo_o)
                && $stable(tag_o) && $stable(sel_o))); // R7

endmodule

// File: rtl/wks_deser.sv
module wks_deser
  import wks_pkg::*;
#(
  parameter int unsigned DATA_W = 68,
  localparam int unsigned KEY_W = DATA_W * PHASES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [KEY_W-1:0]  key_o,
  output logic [IDX_W-1:0]  hi_mask_idx_o,
  output logic [IDX_W-1:0]  lo_mask_idx_o,
  output logic [TAG_W-1:0]  addr_tag_o,
  output logic [SEL_W-1:0]  rslt_sel_o,
  output logic              srch_rdy_o,
  output logic              proto_err_o
);

  logic [PHASES-1:0] cap;

  wks_phase_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (cmd_vld_i),
    .op_i   (cmd_i[1:0]),
    .wide_i (cmd_i[2]),
    .cap_o  (cap),
    .err_o  (proto_err_o)
  );

  wks_field_capture #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (cap),
    .dq_i  (dq_i),
    .idx_i (cmd_i[5:3]),
    .tag_i (cmd_i[8:7]),
    .sel_i (cmd_i[8:6]),
    .key_o (key_o),
    .hi_o  (hi_mask_idx_o),
    .lo_o  (lo_mask_idx_o),
    .tag_o (addr_tag_o),
    .sel_o (rslt_sel_o),
    .rdy_o (srch_rdy_o)
  );

  AST_KEY_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    srch_rdy_o |-> (key_o[DATA_W-1:0] == $past(dq_i))); // R3

  AST_RDY_FROM_SRCH: assert property (@(posedge clk) disable iff (!rst_n)
    srch_rdy_o |-> ($past(cmd_vld_i) && $past(cmd_i[1:0]) == OP_SRCH)); // R2

  AST_RDY_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(srch_rdy_o && proto_err_o)); // R9

endmodule

// File: tb/wks_deser_bench.sv
`timescale 1ns/1ps
module wks_deser_bench;
  localparam int DW = 68;
  localparam int KW = DW * 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vld;
  logic [8:0]    cmd;
  logic [DW-1:0] dq;
  logic [KW-1:0] key_o;
  logic [2:0]    hi_o, lo_o, sel_o;
  logic [1:0]    tag_o;
  logic          rdy_o, err_o;

  always #4 clk = ~clk;

  wks_deser #(.DATA_W(DW)) u_wks_deser (
    .clk(clk), .rst_n(rst_n), .cmd_vld_i(vld), .cmd_i(cmd), .dq_i(dq),
    .key_o(key_o), .hi_mask_idx_o(hi_o), .lo_mask_idx_o(lo_o),
    .addr_tag_o(tag_o), .rslt_sel_o(sel_o),
    .srch_rdy_o(rdy_o), .proto_err_o(err_o)
  );

  int checks = 0;
  int errors = 0;
  logic pend_rdy, pend_err;
  string pend_req;
  logic [KW-1:0] m_key;
  logic [2:0] m_hi, m_lo, m_sel;
  logic [1:0] m_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [KW-1:0] act, input logic [KW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic verify();
    chk(rdy_o === pend_rdy, pend_req, "ready (R6)", KW'(rdy_o), KW'(pend_rdy));
    chk(err_o === pend_err, pend_req, "error (R9/R10)", KW'(err_o), KW'(pend_err));
    chk(key_o === m_key, pend_req, "key (R3/R7)", key_o, m_key);
    chk({hi_o, lo_o, tag_o, sel_o} === {m_hi, m_lo, m_tag, m_sel}, pend_req,
        "idx/tag/sel (R4/R5/R7)", KW'({hi_o, lo_o, tag_o, sel_o}),
        KW'({m_hi, m_lo, m_tag, m_sel}));
  endtask

  task automatic step(input logic v, input logic [8:0] c, input logic [DW-1:0] d,
                      input logic er, input logic ee, input string req);
    @(negedge clk);
    verify();
    vld = v; cmd = c; dq = d;
    pend_rdy = er; pend_err = ee; pend_req = req;
  endtask

  function automatic logic [DW-1:0] mkw(input int i, input int s);
    logic [31:0] a, b;
    a = 32'(i) * 32'h9E37_79B1 ^ 32'(s * 7919);
    b = ~(32'(i + s) * 32'h85EB_CA6B);
    return {4'(s + 1), a, b};
  endfunction

  task automatic send_a(input logic [KW-1:0] k, input logic [2:0] hi,
                        input logic [6:0] j, input string req);
    step(1'b1, {j[2:0], hi, 1'b1, 2'b10}, k[KW-1 -: DW], 1'b0, 1'b0, req);
  endtask

  task automatic send_b(input logic [KW-1:0] k, input logic [6:0] j, input string req);
    step(1'b1, {j, 2'b10}, k[KW-DW-1 -: DW], 1'b0, 1'b0, req);
  endtask

  task automatic send_c(input logic [KW-1:0] k, input logic [2:0] lo, input logic [1:0] tg,
                        input logic [6:0] j, input string req);
    step(1'b1, {tg, j[3], lo, 1'b0, 2'b10}, k[2*DW-1 -: DW], 1'b0, 1'b0, req);
  endtask

  task automatic search(input logic [KW-1:0] k, input logic [2:0] hi, input logic [2:0] lo,
                        input logic [1:0] tg, input logic [2:0] sl, input logic [6:0] j,
                        input string req);
    send_a(k, hi, j, req);
    send_b(k, j, req);
    send_c(k, lo, tg, j, req);
    step(1'b1, {sl, j[3:0], 2'b10}, k[DW-1:0], 1'b1, 1'b0, req);
    m_key = k; m_hi = hi; m_lo = lo; m_tag = tg; m_sel = sl;
  endtask

  function automatic logic [KW-1:0] mkkey(input int i);
    return {mkw(i, 0), mkw(i, 1), mkw(i, 2), mkw(i, 3)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vld = 1'b0; cmd = '0; dq = '0;
    pend_rdy = 1'b0; pend_err = 1'b0; pend_req = "R1";
    m_key = '0; m_hi = '0; m_lo = '0; m_tag = '0; m_sel = '0;
    repeat (3) @(negedge clk);
    verify();                                   // R1 during reset
    rst_n = 1'b1;
    step(1'b0, 9'h000, '0, 1'b0, 1'b0, "R1");

    // R2: non-search cycles while waiting for A are ignored
    step(1'b0, 9'b111_111_1_10, '1, 1'b0, 1'b0, "R2");
    step(1'b1, 9'b111_111_1_01, '1, 1'b0, 1'b0, "R2");
    step(1'b1, 9'b111_111_1_11, '1, 1'b0, 1'b0, "R2");
    step(1'b1, 9'b111_111_1_00, '1, 1'b0, 1'b0, "R2");

    // R3 R4 R5 R6 R8 R11: sweep all hi/lo index pairs, back to back
    for (int i = 0; i < 64; i++) begin
      search(mkkey(i), 3'(i), 3'(i >> 3), 2'(i + 1), 3'(i * 3), 7'(i * 37 + 5), "R3_R4_R5_R8_R11");
    end
    step(1'b0, 9'h000, '0, 1'b0, 1'b0, "R6");

    // R3 boundary keys: all ones then all zeros
    search('1, 3'd7, 3'd7, 2'd3, 3'd7, 7'h00, "R3");
    search('0, 3'd0, 3'd0, 2'd0, 3'd0, 7'h7F, "R3");
    step(1'b0, 9'h000, '0, 1'b0, 1'b0, "R6");

    // R9: break in phase B, C or D by valid drop or wrong opcode
    for (int brk = 1; brk <= 3; brk++) begin
      for (int kind = 0; kind < 3; kind++) begin
        logic [KW-1:0] k;
        logic [8:0] bad;
        k = mkkey(100 + brk * 3 + kind);
        send_a(k, 3'd5, 7'h2A, "R9");
        if (brk >= 2) send_b(k, 7'h15, "R9");
        if (brk >= 3) send_c(k, 3'd2, 2'd1, 7'h33, "R9");
        bad = (kind == 1) ? 9'b000_000_0_01 : (kind == 2) ? 9'b000_000_0_11 : 9'b000_000_0_10;
        step((kind == 0) ? 1'b0 : 1'b1, bad, k[DW-1:0], 1'b0, 1'b1, "R9");
        step(1'b0, 9'h000, '0, 1'b0, 1'b0, "R7");
        search(mkkey(200 + brk * 3 + kind), 3'(brk), 3'(kind), 2'(brk), 3'(kind + 4),
               7'(brk * 11 + kind), "R9");
      end
    end

    // R10: wide flag set in phase C, then a cycle that looks like B
    send_a(mkkey(300), 3'd1, 7'h11, "R10");
    send_b(mkkey(300), 7'h22, "R10");
    step(1'b1, 9'b101_011_1_10, '1, 1'b0, 1'b1, "R10");
    step(1'b1, 9'b010_110_0_10, '1, 1'b0, 1'b1, "R9_not_A");
    step(1'b0, 9'h000, '0, 1'b0, 1'b0, "R7");

    // R10: search with flag clear while waiting for A
    step(1'b1, 9'b111_111_0_10, '1, 1'b0, 1'b1, "R10");
    search(mkkey(301), 3'd6, 3'd3, 2'd2, 3'd1, 7'h0F, "R10");
    step(1'b0, 9'h000, '0, 1'b0, 1'b0, "R6");

    @(negedge clk);
    verify();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule